// File: doc/BRIEF.md
# Variable-Length Pattern Bus Decoder

This block sits at the receiving end of a power-reducing off-chip data link. The transmitter replaces recurring groups of 32-bit words with short symbols that point into a cached pattern table. The decoder rebuilds the original word stream from those symbols. It keeps its own 64-entry pattern table, which is read directly by index. It updates that table in step with the transmitter, so that both sides hold the same contents at all times.

Each symbol is one of four kinds.
- A **raw** symbol carries 1 to 4 literal words. They are emitted unchanged and stored into the table slot chosen by a round-robin write pointer. The pointer starts at slot 0 and follows the same sequence as the transmitter's pointer.
- A **full-match** symbol carries only an index. The stored pattern at that index is emitted with its stored length.
- A **partial-match** symbol carries an index, a prefix count k, a total length, and the unmatched words. The output is the first k words of the stored entry, followed by the received words.
- A **reserved** kind is consumed and has no effect.

Symbols arrive on a valid/ready stream. Words leave on a valid/ready stream, one per cycle, with a flag on the last word of each pattern. A new symbol is taken only after the previous pattern has fully drained. A match symbol that points at an empty slot sets a sticky error flag.

Top module: `vlp_decoder`

## Requirements
- R1: After reset, `sym_ready` is 1, `out_valid` is 0, `err` is 0, and every table slot is empty.
- R2: A raw symbol (`sym_kind` = 2'b00) emits words 0 to `sym_len` of `sym_data`, in that order. Word j sits in bits [32j+31:32j]. `sym_len` holds the word count minus one. `out_last` is 1 on the final word only.
- R3: Each raw symbol stores its words and length into the slot named by the write pointer. The pointer is 0 after reset. It advances by one per raw symbol only, and wraps from 63 to 0. `sym_index` is ignored for raw symbols.
- R4: A full-match symbol (`sym_kind` = 2'b01) emits the words stored at `sym_index`, using the stored length.
- R5: A partial-match symbol (`sym_kind` = 2'b10) emits `sym_len`+1 words. Output word j is stored word j of entry `sym_index` when j < `sym_pfx`. Otherwise it is received word j−`sym_pfx`.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R7: `sym_ready` is 0 while a pattern is being emitted. After the last word is taken, `out_valid` is 0 and `sym_ready` is 1 on the next cycle.
- R8: A match symbol that names an empty slot sets `err`, which stays 1 until reset. That symbol is consumed, emits no word, and leaves the table and pointer unchanged.
- R9: A reserved symbol (`sym_kind` = 2'b11) is consumed, emits no word, and leaves the table, the pointer and `err` unchanged.
- R10: Match symbols never write the table and never move the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | Symbol present |
| sym_ready | output | 1 | Decoder can take a symbol |
| sym_kind | input | 2 | 00 raw, 01 full match, 10 partial match, 11 reserved |
| sym_index | input | 6 | Table slot for match symbols |
| sym_len | input | 2 | Output word count minus one (raw and partial) |
| sym_pfx | input | 2 | Number of words taken from the table (partial) |
| sym_data | input | 128 | Received words, word j in bits [32j+31:32j] |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 32 | Reconstructed word |
| out_last | output | 1 | Final word of a pattern |
| err | output | 1 | Sticky flag: a match named an empty slot |

## Verification
A wrong table slot or a wrong write-pointer step is invisible when it happens. It shows up only when a later full-match or partial-match symbol names that slot, and then appears as wrong words or a wrong pattern length. For that reason the bench fills every slot, reads every slot back, and wraps the pointer to rewrite the first slots. A wrong word counter shows up within the same pattern, as a misplaced `out_last` or a repeated word. A wrong busy state shows up one cycle after the last word, as `sym_ready` failing to return or a spurious extra word.

// File: rtl/vlpd_pkg.sv
// Package: shared symbol-kind encoding for the pattern decoder.
// Assumes the 2-bit kind field on the symbol interface.
package vlpd_pkg;
    typedef enum logic [1:0] {
        KIND_RAW  = 2'b00,
        KIND_FULL = 2'b01,
        KIND_PART = 2'b10,
        KIND_RSVD = 2'b11
    } sym_kind_e;
endpackage

// File: rtl/vlp_pattern_store.sv
// Module: directly indexed pattern table with a round-robin write pointer.
// Reads are combinational by index. A write lands at the pointer, which
// then advances and wraps after DEPTH-1. Only the valid bits and the
// pointer are reset; the data arrays are qualified by the valid bits.
module vlp_pattern_store #(
    parameter int WORD_W  = 32,
    parameter int MAX_LEN = 4,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int PAT_W  = WORD_W * MAX_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PAT_W-1:0] wr_words,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PAT_W-1:0] rd_words,
    output logic [LEN_W-1:0] rd_len,
    output logic             rd_hit
);
    logic [PAT_W-1:0] pat_mem [DEPTH];
    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [DEPTH-1:0] slot_full;
    logic [IDX_W-1:0] wr_ptr;

    // Pointer and occupancy: clear on reset, step on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_full <= '0;
            wr_ptr    <= '0;
        end else if (wr_en) begin
            slot_full[wr_ptr] <= 1'b1;
            wr_ptr <= (wr_ptr == IDX_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Data arrays: store the pattern and its length at the pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            pat_mem[wr_ptr] <= wr_words;
            len_mem[wr_ptr] <= wr_len;
        end
    end

    // Read port: direct index, no search.
    assign rd_words = pat_mem[rd_idx];
    assign rd_len   = len_mem[rd_idx];
    assign rd_hit   = slot_full[rd_idx];
endmodule

// File: rtl/vlp_pattern_assembler.sv
// Module: builds the complete output pattern from the symbol and the
// table entry it names. Purely combinational. Assumes that for a partial
// match the unmatched words are packed from word 0 of the symbol data.
module vlp_pattern_assembler
    import vlpd_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int MAX_LEN = 4,
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int PAT_W  = WORD_W * MAX_LEN
) (
    input  sym_kind_e        kind,
    input  logic [PAT_W-1:0] tbl_words,
    input  logic [LEN_W-1:0] tbl_len,
    input  logic [PAT_W-1:0] sym_words,
    input  logic [LEN_W-1:0] sym_len,
    input  logic [LEN_W-1:0] sym_pfx,
    output logic [PAT_W-1:0] pat_words,
    output logic [LEN_W-1:0] pat_len
);
    logic [MAX_LEN-1:0][WORD_W-1:0] tbl_w;
    logic [MAX_LEN-1:0][WORD_W-1:0] sym_w;
    logic [MAX_LEN-1:0][WORD_W-1:0] pat_w;

    assign tbl_w = tbl_words;
    assign sym_w = sym_words;

    for (genvar j = 0; j < MAX_LEN; j++) begin : g_slot
        // Per output slot: choose table word, literal word or shifted tail word.
        always_comb begin
            int src;
            src      = j - int'(sym_pfx);
            pat_w[j] = tbl_w[j];
            case (kind)
                KIND_RAW:  pat_w[j] = sym_w[j];
                KIND_PART: if (src >= 0) pat_w[j] = sym_w[src[LEN_W-1:0]];
                default:   pat_w[j] = tbl_w[j];
            endcase
        end
    end

    assign pat_words = pat_w;
    // Length: the table's own for a full match, the symbol's otherwise.
    assign pat_len   = (kind == KIND_FULL) ? tbl_len : sym_len;
endmodule

// File: rtl/vlp_word_sequencer.sv
// Module: holds one assembled pattern and emits it one word per cycle on
// a valid/ready stream, marking the final word. Assumes load is raised
// only while busy is low.
module vlp_word_sequencer #(
    parameter int WORD_W  = 32,
    parameter int MAX_LEN = 4,
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int PAT_W  = WORD_W * MAX_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAT_W-1:0]  ld_words,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              out_ready,
    output logic              busy,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last
);
    logic [MAX_LEN-1:0][WORD_W-1:0] words_q;
    logic [LEN_W-1:0]               len_q;
    logic [LEN_W-1:0]               cnt_q;

    // Control: start on load, step on each accepted word, stop after last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            len_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            len_q <= ld_len;
        end else if (busy && out_ready) begin
            if (cnt_q == len_q) busy <= 1'b0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pattern buffer: capture the assembled words at load.
    always_ff @(posedge clk) begin
        if (load) words_q <= ld_words;
    end

    assign out_valid = busy;
    assign out_data  = words_q[cnt_q];
    assign out_last  = busy && (cnt_q == len_q);
endmodule

// File: rtl/vlp_decoder.sv
// Module: top of the variable-length pattern decoder. Accepts one symbol
// at a time, assembles the pattern from table and symbol, writes raw
// patterns into the table and raises a sticky flag on empty-slot matches.
// Assumes the transmitter's table follows the same round-robin policy.
module vlp_decoder
    import vlpd_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int MAX_LEN = 4,
    parameter int DEPTH   = 64,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int PAT_W  = WORD_W * MAX_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    output logic              sym_ready,
    input  logic [1:0]        sym_kind,
    input  logic [IDX_W-1:0]  sym_index,
    input  logic [LEN_W-1:0]  sym_len,
    input  logic [LEN_W-1:0]  sym_pfx,
    input  logic [PAT_W-1:0]  sym_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic              err
);
    sym_kind_e        kind;
    logic             accept, is_raw, is_match, busy;
    logic [PAT_W-1:0] tbl_words, pat_words;
    logic [LEN_W-1:0] tbl_len, pat_len;
    logic             tbl_hit;

    assign kind     = sym_kind_e'(sym_kind);
    assign sym_ready = !busy;
    assign accept   = sym_valid && sym_ready;
    assign is_raw   = (kind == KIND_RAW);
    assign is_match = (kind == KIND_FULL) || (kind == KIND_PART);

    vlp_pattern_store #(
        .WORD_W(WORD_W), .MAX_LEN(MAX_LEN), .DEPTH(DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept && is_raw),
        .wr_words (sym_data),
        .wr_len   (sym_len),
        .rd_idx   (sym_index),
        .rd_words (tbl_words),
        .rd_len   (tbl_len),
        .rd_hit   (tbl_hit)
    );

    vlp_pattern_assembler #(
        .WORD_W(WORD_W), .MAX_LEN(MAX_LEN)
    ) u_asm (
        .kind      (kind),
        .tbl_words (tbl_words),
        .tbl_len   (tbl_len),
        .sym_words (sym_data),
        .sym_len   (sym_len),
        .sym_pfx   (sym_pfx),
        .pat_words (pat_words),
        .pat_len   (pat_len)
    );

    vlp_word_sequencer #(
        .WORD_W(WORD_W), .MAX_LEN(MAX_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && (is_raw || (is_match && tbl_hit))),
        .ld_words  (pat_words),
        .ld_len    (pat_len),
        .out_ready (out_ready),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // Sticky flag: any accepted match that names an empty slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                             err <= 1'b0;
        else if (accept && is_match && !tbl_hit) err <= 1'b1;
    end
endmodule

// File: rtl/vlp_decoder_checker.sv
// Module: protocol checks on the decoder ports, attached by bind.
// Assumes synchronous active-low reset.
module vlp_decoder_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_valid,
    input logic              sym_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last,
    input logic              err
);
    // R1: one cycle of reset leaves the block idle and clean.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sym_ready && !err));

    // R7: no symbol is taken while a pattern is draining.
    p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !sym_ready);

    // R7: taking the last word frees the input on the next cycle.
    p_free_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && sym_ready));

    // R6: a stalled word holds still.
    p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    // R8: the error flag never clears outside reset.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind vlp_decoder vlp_decoder_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .err       (err)
);

// File: tb/tb_vlp_decoder.sv
module tb_vlp_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sym_valid = 1'b0;
    logic         sym_ready;
    logic [1:0]   sym_kind = 2'b00;
    logic [5:0]   sym_index = '0;
    logic [1:0]   sym_len = '0;
    logic [1:0]   sym_pfx = '0;
    logic [127:0] sym_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [31:0]  out_data;
    logic         out_last;
    logic         err;

    vlp_decoder dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_kind(sym_kind), .sym_index(sym_index), .sym_len(sym_len),
        .sym_pfx(sym_pfx), .sym_data(sym_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .err(err)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0, n_fail = 0, cyc = 0, wd = 0;
    bit bp = 0;
    logic [31:0] m_tbl [64][4];
    int  m_len [64];
    int  m_ptr = 0, raw_n = 0;
    logic [31:0] exp_w [4];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL R7: watchdog expired, actual hang expected completion");
            summary();
            $finish;
        end
    end

    task automatic send(input logic [1:0] k, input int idx, input int lm1, input int pf, input logic [127:0] d);
        sym_kind = k; sym_index = 6'(idx); sym_len = 2'(lm1); sym_pfx = 2'(pf); sym_data = d;
        sym_valid = 1'b1;
        while (!sym_ready) @(negedge clk);
        @(posedge clk);
        #1 sym_valid = 1'b0;
    endtask

    task automatic collect(input int n, input string req);
        int got = 0;
        bit hold = 0;
        logic [31:0] hd;
        logic hl;
        while (got < n) begin
            @(negedge clk);
            cyc++;
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            #1;
            if (hold) chk(out_valid && out_data == hd && out_last == hl, "R6", out_data, hd);
            hold = 0;
            if (out_valid) begin
                chk(!sym_ready, "R7", 32'(sym_ready), 32'd0);
                if (out_ready) begin
                    chk(out_data == exp_w[got], req, out_data, exp_w[got]);
                    chk(out_last == (got == n - 1), req, 32'(out_last), 32'(got == n - 1));
                    got++;
                end else begin
                    hold = 1; hd = out_data; hl = out_last;
                end
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
        chk(!out_valid && sym_ready, "R7", {30'd0, out_valid, sym_ready}, 32'd1);
    endtask

    task automatic send_none(input logic [1:0] k, input int idx, input string req);
        send(k, idx, 3, 1, {4{32'hBAD0_0BAD}});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!out_valid, req, 32'(out_valid), 32'd0);
        end
        chk(sym_ready, req, 32'(sym_ready), 32'd1);
    endtask

    task automatic do_raw(input int len);
        logic [127:0] d;
        for (int j = 0; j < 4; j++) begin
            d[32*j +: 32] = (j < len) ? {8'h5A, 8'(raw_n), 8'(j), 8'(len)} : 32'hDEAD_0000 + 32'(j);
            exp_w[j] = d[32*j +: 32];
        end
        send(2'b00, raw_n * 7 + 3, len - 1, 3, d);
        collect(len, "R2");
        for (int j = 0; j < 4; j++) m_tbl[m_ptr][j] = d[32*j +: 32];
        m_len[m_ptr] = len;
        m_ptr = (m_ptr + 1) % 64;
        raw_n++;
    endtask

    task automatic do_full(input int idx, input string req);
        for (int j = 0; j < 4; j++) exp_w[j] = m_tbl[idx][j];
        send(2'b01, idx, 0, 2, {4{32'hFFFF_0000}});
        collect(m_len[idx], req);
    endtask

    task automatic do_part(input int idx, input int k, input int len);
        logic [127:0] d;
        for (int j = 0; j < 4; j++) d[32*j +: 32] = {8'hEE, 8'(idx), 8'(k), 8'(j)};
        for (int j = 0; j < 4; j++) exp_w[j] = (j < k) ? m_tbl[idx][j] : d[32*(j-k) +: 32];
        send(2'b10, idx, len - 1, k, d);
        collect(len, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle and clean after reset
        chk(sym_ready, "R1", 32'(sym_ready), 32'd1);
        chk(!out_valid, "R1", 32'(out_valid), 32'd0);
        chk(!err, "R1", 32'(err), 32'd0);
        // R8 / R1: every slot empty, so a match is flagged and emits nothing
        send_none(2'b01, 5, "R8");
        chk(err, "R8", 32'(err), 32'd1);
        send_none(2'b10, 40, "R8");
        chk(err, "R8", 32'(err), 32'd1);
        // R2 / R3: fill all slots through raw symbols of every length
        for (int n = 0; n < 64; n++) begin
            if (n == 10) send_none(2'b11, 0, "R9");   // R9: reserved kind, no effect
            bp = (n >= 32);
            do_raw((n % 4) + 1);
        end
        // R4 / R10: read back every slot
        for (int i = 0; i < 64; i++) begin
            bp = (i % 2 == 1);
            do_full(i, "R4");
        end
        // R5: every prefix/length split on slots holding four words
        for (int i = 3; i < 64; i += 4)
            for (int k = 1; k < 4; k++)
                for (int len = k + 1; len <= 4; len++) begin
                    bp = ((i + k + len) % 2 == 0);
                    do_part(i, k, len);
                end
        // R3 / R10: pointer wraps to slot 0 after the matches above
        bp = 1;
        for (int n = 0; n < 8; n++) do_raw((n % 4) + 1);
        for (int i = 0; i < 10; i++) do_full(i, "R3");
        do_full(63, "R3");
        chk(err, "R8", 32'(err), 32'd1);
        summary();
        $finish;
    end
endmodule